// File: doc/BRIEF.md
# Per-Bit Access-Policy Register Bank

This block is a small bank of 32-bit control and status registers. It sits behind a simple memory-mapped bus that carries an address, write data, separate read and write strobes, and an access size of one, two or four bytes. Every register has its own address and reset value, set at build time. Each one also has five per-bit policy masks. These mark bits as read-only, write-one-to-clear, reserved, clear-on-read or unimplemented.

A write is merged with the register's current contents. Protected bits keep their stored value and all other bits take the bus data. Write-one-to-clear bits are then cleared wherever the data holds a one. A read returns the stored value masked to the access width, one cycle after the strobe. The read also clears any clear-on-read bit inside that width. Three diagnostic pulses report problems:
- a bus access that matches no register;
- a write that tries to change a reserved bit;
- a write that sets an unimplemented bit.

Top module: `policy_regbank`

## Requirements
- R1: After reset each register reads back its own configured reset value, and the read data and all three error flags are 0. With the default build, address 0x00 resets to 0x110030A5, 0x04 to 0x0000ABFF, 0x08 to 0x5A5A5A5A and 0x10 to 0xDEADBEEF.
- R2: On a write, bits that are read-only, reserved or outside the write enable keep their old value. Every other bit takes the written data. Unimplemented bits are stored like ordinary bits.
- R3: A write-one-to-clear bit is forced to 0 when the written data holds a 1 at that position. It is left unchanged when the data holds a 0.
- R4: The write enable covers the low bytes only. Size code 0 enables 1 byte, code 1 enables 2 bytes, and codes 2 and 3 enable 4 bytes. The count is capped at the register size.
- R5: Read data appears on the cycle after the read strobe. It holds the register value from before any clearing, masked to the access width given by the same size codes. It holds its value while no read is issued.
- R6: After a read, every clear-on-read bit inside the read width is 0 in storage. Clear-on-read bits outside that width keep their value.
- R7: A register is selected only by an exact match of the whole address. A write to an unmapped address changes no register. A read from an unmapped address returns 0. Either access raises err_unmapped.
- R8: err_rsvd is raised when a write to a mapped register has data that differs from the stored value in a reserved bit inside the write enable. The reserved bit keeps its old value.
- R9: err_unimp is raised when a write to a mapped register carries a 1 in an unimplemented bit inside the write enable.
- R10: Each error flag is a one-cycle pulse in the cycle after the strobe that caused it. It is 0 in any cycle that follows a cycle with no access.
- R11: When read and write strobes arrive together, the read data returns the value held before the write. Storage takes the merged write value, with the in-width clear-on-read bits then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| rd_data | output | 32 | Registered read data |
| err_unmapped | output | 1 | Pulse for an access to an address with no register |
| err_rsvd | output | 1 | Pulse for an attempted change of a reserved bit |
| err_unimp | output | 1 | Pulse for a write of a 1 to an unimplemented bit |

## Verification
The assertions check the following on every cycle:
- read-only and reserved bits never move outside reset;
- write-one-to-clear bits never go from 0 to 1;
- clear-on-read bits inside the read width are 0 after a read;
- read data holds between reads, and is 0 after an unmapped read;
- every error pulse follows an access of the right kind.

Only the bench scenarios can show the exact merged values. These cover narrow writes that touch only the low byte or half, and the width masking of read data. They also cover the exact address match, the rule that reserved-change detection is limited to the write enable, and the ordering of a read and a write in the same cycle.

// File: rtl/policy_regbank_pkg.sv
package policy_regbank_pkg;

  localparam int DATA_W    = 32;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = DATA_W / LANE_W;

  // Access size codes carried on the bus
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  // Low-lane enable mask: min(register bytes, access bytes) lanes set
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz,
                                                   input int reg_bytes);
    int nbytes;
    logic [DATA_W-1:0] m;
    case (acc_size_e'(sz))
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      default: nbytes = 4;
    endcase
    if (reg_bytes < nbytes) nbytes = reg_bytes;
    m = '0;
    for (int b = 0; b < NUM_LANES; b++) begin
      if (b < nbytes) m[b*LANE_W +: LANE_W] = '1;
    end
    return m;
  endfunction

endpackage

// File: rtl/policy_regbank_rst_sync.sv
module policy_regbank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/policy_regbank_decode.sv
module policy_regbank_decode #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 8,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit,
  output logic                any_hit
);

  // Exact whole-address comparison per register
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_match
    assign hit[i] = (addr == REG_ADDR[i]);
  end

  assign any_hit = |hit;

endmodule

// File: rtl/policy_regbank_cell.sv
module policy_regbank_cell
  import policy_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  parameter logic [DATA_W-1:0] RO_MASK   = '0,
  parameter logic [DATA_W-1:0] W1C_MASK  = '0,
  parameter logic [DATA_W-1:0] RSVD_MASK = '0,
  parameter logic [DATA_W-1:0] COR_MASK  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wmask,
  input  logic [DATA_W-1:0] rmask,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] after_wr;
  logic [DATA_W-1:0] q_nxt;
  logic              upd_en;

  always_comb begin
    keep_mask = RO_MASK | W1C_MASK | RSVD_MASK | ~wmask;
    merged    = (wdata & ~keep_mask) | (q & keep_mask);
    merged    = merged & ~(wdata & W1C_MASK);
    after_wr  = wr_hit ? merged : q;
    q_nxt     = rd_hit ? (after_wr & ~(COR_MASK & rmask)) : after_wr;
    upd_en    = wr_hit | rd_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RESET_VAL;
    else if (upd_en) q <= q_nxt;
  end

  // R2: read-only bits never move after reset
  p_ro_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & RO_MASK) == ($past(q) & RO_MASK)));

  // R8: reserved bits never move after reset
  p_rsvd_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & RSVD_MASK) == ($past(q) & RSVD_MASK)));

  // R3: write-one-to-clear bits can only fall
  p_w1c_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~$past(q) & W1C_MASK) == '0));

  // R6: in-width clear-on-read bits are zero after a read
  p_cor_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> ((q & COR_MASK & $past(rmask)) == '0));

endmodule

// File: rtl/policy_regbank_rdmux.sv
module policy_regbank_rdmux
  import policy_regbank_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_stb,
  input  logic [NUM_REGS-1:0]              hit,
  input  logic                             any_hit,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  input  logic [DATA_W-1:0]                rmask,
  output logic [DATA_W-1:0]                rd_data
);

  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) sel = sel | regs[i];
    end
    rd_nxt = any_hit ? (sel & rmask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_nxt;
  end

  // R5: read data holds while no read is issued
  p_rd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  // R7: unmapped read returns zero
  p_unmapped_rd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !any_hit) |=> (rd_data == '0));

endmodule

// File: rtl/policy_regbank.sv
module policy_regbank
  import policy_regbank_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int ADDR_W    = 8,
  parameter int REG_BYTES = 4,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR =
    {8'h10, 8'h08, 8'h04, 8'h00},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] RESET_VAL =
    {32'hDEAD_BEEF, 32'h5A5A_5A5A, 32'h0000_ABFF, 32'h1100_30A5},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] RO_MASK =
    {32'h0, 32'h0, 32'h0000_FF00, 32'hFF00_0000},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] W1C_MASK =
    {32'h0, 32'h0, 32'h0000_00FF, 32'h0},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] RSVD_MASK =
    {32'h0, 32'h0, 32'h0, 32'h0000_F000},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] COR_MASK =
    {32'h0, 32'hFFFF_0000, 32'h0, 32'h0},
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] UNIMP_MASK =
    {32'h0, 32'h0, 32'h0, 32'h00F0_0000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_unmapped,
  output logic              err_rsvd,
  output logic              err_unimp
);

  logic                             rst_sync_n;
  logic [NUM_REGS-1:0]              hit;
  logic                             any_hit;
  logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q;
  logic [DATA_W-1:0]                acc_mask;
  logic [NUM_REGS-1:0]              rsvd_viol;
  logic [NUM_REGS-1:0]              unimp_viol;
  logic                             unmapped_nxt;
  logic                             rsvd_nxt;
  logic                             unimp_nxt;

  policy_regbank_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  policy_regbank_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
  ) u_decode (
    .addr    (bus_addr),
    .hit     (hit),
    .any_hit (any_hit)
  );

  // Same mask serves write enable and read width
  assign acc_mask = lane_mask(bus_size, REG_BYTES);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    policy_regbank_cell #(
      .RESET_VAL (RESET_VAL[i]),
      .RO_MASK   (RO_MASK[i]),
      .W1C_MASK  (W1C_MASK[i]),
      .RSVD_MASK (RSVD_MASK[i]),
      .COR_MASK  (COR_MASK[i])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wr_hit (bus_wr & hit[i]),
      .rd_hit (bus_rd & hit[i]),
      .wdata  (bus_wdata),
      .wmask  (acc_mask),
      .rmask  (acc_mask),
      .q      (reg_q[i])
    );

    assign rsvd_viol[i]  = bus_wr & hit[i] &
                           (|((reg_q[i] ^ bus_wdata) & RSVD_MASK[i] & acc_mask));
    assign unimp_viol[i] = bus_wr & hit[i] &
                           (|(bus_wdata & UNIMP_MASK[i] & acc_mask));
  end

  policy_regbank_rdmux #(.NUM_REGS(NUM_REGS)) u_rdmux (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_stb  (bus_rd),
    .hit     (hit),
    .any_hit (any_hit),
    .regs    (reg_q),
    .rmask   (acc_mask),
    .rd_data (rd_data)
  );

  always_comb begin
    unmapped_nxt = (bus_rd | bus_wr) & ~any_hit;
    rsvd_nxt     = |rsvd_viol;
    unimp_nxt    = |unimp_viol;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      err_unmapped <= 1'b0;
      err_rsvd     <= 1'b0;
      err_unimp    <= 1'b0;
    end else begin
      err_unmapped <= unmapped_nxt;
      err_rsvd     <= rsvd_nxt;
      err_unimp    <= unimp_nxt;
    end
  end

  // R7: an access with no match raises the unmapped pulse next cycle
  p_unmapped_flag_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_rd || bus_wr) && !any_hit) |=> err_unmapped);

  // R10: no access, no pulse
  p_quiet_after_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_rd && !bus_wr) |=> (!err_unmapped && !err_rsvd && !err_unimp));

  // R8: reserved-change pulse only follows a write
  p_rsvd_after_write_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_rsvd |-> $past(bus_wr && any_hit));

  // R9: unimplemented-write pulse only follows a mapped write
  p_unimp_after_write_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_unimp |-> $past(bus_wr && any_hit));

endmodule

// File: tb/policy_regbank_bench.sv
module policy_regbank_bench;

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  sz;
    logic        chk;
    logic [31:0] exp;
    logic        um;
    logic        rs;
    logic        ui;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  // Fields: rd, wr, addr, data, size, check-read, expected read, um, rs, ui, req
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,8'h00,32'h0,2'd2,1'b1,32'h1100_30A5,1'b0,1'b0,1'b0,4'd1},  // R1
    '{1'b1,1'b0,8'h04,32'h0,2'd2,1'b1,32'h0000_ABFF,1'b0,1'b0,1'b0,4'd1},  // R1
    '{1'b1,1'b0,8'h08,32'h0,2'd2,1'b1,32'h5A5A_5A5A,1'b0,1'b0,1'b0,4'd5},  // R5
    '{1'b1,1'b0,8'h08,32'h0,2'd2,1'b1,32'h0000_5A5A,1'b0,1'b0,1'b0,4'd6},  // R6
    '{1'b0,1'b1,8'h00,32'hFFFF_FFFF,2'd2,1'b0,32'h0,1'b0,1'b1,1'b1,4'd8},  // R8 R9
    '{1'b1,1'b0,8'h00,32'h0,2'd2,1'b1,32'h11FF_3FFF,1'b0,1'b0,1'b0,4'd2},  // R2 R9
    '{1'b0,1'b1,8'h00,32'h0,2'd0,1'b0,32'h0,1'b0,1'b0,1'b0,4'd4},          // R4
    '{1'b1,1'b0,8'h00,32'h0,2'd1,1'b1,32'h0000_3F00,1'b0,1'b0,1'b0,4'd5},  // R5
    '{1'b1,1'b0,8'h00,32'h0,2'd2,1'b1,32'h11FF_3F00,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b0,1'b1,8'h04,32'h0000_0003,2'd2,1'b0,32'h0,1'b0,1'b0,1'b0,4'd3},  // R3
    '{1'b1,1'b0,8'h04,32'h0,2'd2,1'b1,32'h0000_ABFC,1'b0,1'b0,1'b0,4'd3},  // R3
    '{1'b0,1'b1,8'h04,32'h0,2'd2,1'b0,32'h0,1'b0,1'b0,1'b0,4'd3},          // R3
    '{1'b1,1'b0,8'h04,32'h0,2'd2,1'b1,32'h0000_ABFC,1'b0,1'b0,1'b0,4'd3},  // R3
    '{1'b0,1'b1,8'h0C,32'hFFFF_FFFF,2'd2,1'b0,32'h0,1'b1,1'b0,1'b0,4'd7},  // R7
    '{1'b1,1'b0,8'h0C,32'h0,2'd2,1'b1,32'h0,1'b1,1'b0,1'b0,4'd7},          // R7
    '{1'b1,1'b0,8'h01,32'h0,2'd2,1'b1,32'h0,1'b1,1'b0,1'b0,4'd7},          // R7
    '{1'b0,1'b1,8'h10,32'h1234_5678,2'd1,1'b0,32'h0,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b1,1'b0,8'h10,32'h0,2'd2,1'b1,32'hDEAD_5678,1'b0,1'b0,1'b0,4'd4},  // R4
    '{1'b1,1'b0,8'h10,32'h0,2'd0,1'b1,32'h0000_0078,1'b0,1'b0,1'b0,4'd5},  // R5
    '{1'b0,1'b1,8'h00,32'h0000_C0FF,2'd0,1'b0,32'h0,1'b0,1'b0,1'b0,4'd8},  // R8
    '{1'b1,1'b0,8'h00,32'h0,2'd2,1'b1,32'h11FF_3FFF,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b0,1'b1,8'h08,32'hFFFF_1234,2'd2,1'b0,32'h0,1'b0,1'b0,1'b0,4'd2},  // R2
    '{1'b1,1'b0,8'h08,32'h0,2'd0,1'b1,32'h0000_0034,1'b0,1'b0,1'b0,4'd6},  // R6
    '{1'b1,1'b0,8'h08,32'h0,2'd2,1'b1,32'hFFFF_1234,1'b0,1'b0,1'b0,4'd6},  // R6
    '{1'b1,1'b0,8'h08,32'h0,2'd2,1'b1,32'h0000_1234,1'b0,1'b0,1'b0,4'd6}   // R6
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [1:0]  bus_size;
  logic [31:0] rd_data;
  logic        err_unmapped;
  logic        err_rsvd;
  logic        err_unimp;

  int checks;
  int errors;
  bit finished;

  policy_regbank u_policy_regbank (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_size     (bus_size),
    .rd_data      (rd_data),
    .err_unmapped (err_unmapped),
    .err_rsvd     (err_rsvd),
    .err_unimp    (err_unimp)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input int req, input logic um, input logic rs,
                             input logic ui);
    check(req, "flags {unmapped,rsvd,unimp}",
          {29'd0, err_unmapped, err_rsvd, err_unimp}, {29'd0, um, rs, ui});
  endtask

  // Drive one access at a falling edge; returns one falling edge later
  task automatic access(input logic r, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [1:0] s);
    bus_rd    = r;
    bus_wr    = w;
    bus_addr  = a;
    bus_wdata = d;
    bus_size  = s;
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    rst_n = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; bus_size = 2'd2;
    repeat (3) @(negedge clk);
    // R1: reset state of outputs
    check(1, "rd_data in reset", rd_data, 32'h0);
    check_flags(1, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].rd, VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].sz);
      if (VECS[i].chk) check(int'(VECS[i].req), "vector read data", rd_data, VECS[i].exp);
      check_flags(int'(VECS[i].req), VECS[i].um, VECS[i].rs, VECS[i].ui);
    end

    // R10: pulse drops after an idle cycle
    access(1'b0, 1'b1, 8'h0C, 32'h0, 2'd2);
    check_flags(10, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    check_flags(10, 1'b0, 1'b0, 1'b0);

    // R11: read and write together on the clear-on-read register
    access(1'b1, 1'b1, 8'h08, 32'hCAFE_F00D, 2'd2);
    check(11, "simultaneous rd returns old value", rd_data, 32'h0000_1234);
    access(1'b1, 1'b0, 8'h08, 32'h0, 2'd2);
    check(11, "stored value after rd+wr", rd_data, 32'h0000_F00D);

    // R1: reset again restores configured values
    rst_n = 1'b0;
    @(negedge clk);
    check(1, "rd_data cleared by reset", rd_data, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b1, 1'b0, 8'h10, 32'h0, 2'd2);
    check(1, "reset value of 0x10", rd_data, 32'hDEAD_BEEF);
    access(1'b1, 1'b0, 8'h08, 32'h0, 2'd2);
    check(1, "reset value of 0x08", rd_data, 32'h5A5A_5A5A);
    access(1'b1, 1'b0, 8'h00, 32'h0, 2'd2);
    check(1, "reset value of 0x00", rd_data, 32'h1100_30A5);

    finish_run();
  end

endmodule